// File: doc/BRIEF.md
# Resolver Signal Synthesizer with Fault Injection

This block stands in for a resolver's two secondary windings. Each time a new excitation sample arrives, it multiplies that sample by the sine and the cosine of a simulated shaft angle. The two signed results go to a pair of DACs. Because the carrier is the live excitation, the shaft position is carried by the envelope. In position mode that envelope is fixed. In velocity mode the angle advances by a programmed step on every sample, so the envelope turns at the commanded electrical speed.

A fault stage sits between the modulator and the outputs. It is programmed through an eight-word register port and can do the following:
- scale each channel by its own gain;
- delay each channel by its own number of samples;
- exchange the two channels or invert either one;
- push the peaks into the rails;
- add a periodic spike to both channels;
- force both lines to zero, as a broken wire would.

Register writes collect in a shadow copy. That copy is only taken over on a sample strobe, so every output sample is made under a single, whole configuration.

Top module: `rsv_synth`

## Requirements
- R1: After reset both outputs and `out_vld` are zero. Each `smp_vld` strobe produces one new output pair with `out_vld` high in the next cycle. Outputs hold their value between strobes.
- R2: In position mode (control bit 0 clear), the output is sin_out ≈ exc·16·sin(2π·A/65536)·Gs/32768, and cos_out is the same with the cosine and Gc. A is the 16-bit angle register (address 1). Gs and Gc are the gain registers (addresses 4 and 5, reset value 0x8000 = unity). The tolerance is 48 LSB.
- R3: The sign of each output follows the quadrant of the angle: it matches the excitation where the sine or cosine is positive and is opposite where it is negative.
- R4: In velocity mode (control bit 0 set) a 32-bit accumulator adds the step register on every strobe. The step's upper half is at address 2 and its lower half at address 3. The angle used is the accumulator's upper 16 bits. The accumulator starts from the angle register shifted into the upper half.
- R5: Gs and Gc act independently, so unequal values give unequal amplitudes on the two channels.
- R6: With control bit 1 set, both outputs are exactly zero.
- R7: Control bit 2 exchanges the two channel results. Bits 3 and 4 then negate the value presented on sin_out and cos_out respectively.
- R8: Results saturate to the range −524288..524287 and never wrap. Control bit 5 multiplies both channels by 4 before this limit is applied.
- R9: When the period register (address 7, bits 7:0) holds P > 0, a spike of +131072 is added to both channels. It appears on the first sample made with P and then on every P-th sample after that.
- R10: Address 6 holds the sin delay in bits 7:0 and the cos delay in bits 15:8. A delay of d makes a channel output the modulated sample from d strobes earlier.
- R11: A register write has no effect on the output made by the next strobe. It takes effect from the strobe after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: a new excitation sample is present |
| exc_in | input | 16 | Signed excitation sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| out_vld | output | 1 | New output pair available |
| sin_out | output | 20 | Signed sine-channel word |
| cos_out | output | 20 | Signed cosine-channel word |

## Verification
The hardest states to reach are the ones where time and configuration interact: a delayed channel reading history, a spike counter running against the sample count, and the accumulator carrying sub-LSB fractions. The bench reaches them by driving strobes in programmed runs with distinct excitation values. From that known history it predicts which past sample each channel must show. It uses a fractional velocity step so that the accumulator's lower half visibly moves the angle on alternate samples. Configuration changes are placed between strobes, and the one-strobe lag is checked directly.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;
  localparam int EXC_W  = 16;
  localparam int ANG_W  = 16;
  localparam int ACC_W  = 32;
  localparam int TRIG_W = 18;                 // unity == 2**(TRIG_W-2)
  localparam int OUT_W  = 20;
  localparam int PROD_W = OUT_W + 2;
  localparam int WIDE_W = 32;
  localparam int GAIN_W = 16;                 // unity == 2**(GAIN_W-1)
  localparam int DLY_AW = 8;
  localparam int MOD_SH  = (EXC_W - 1) + (TRIG_W - 2) - (OUT_W - 1);
  localparam int GAIN_SH = GAIN_W - 1;

  typedef struct packed {
    logic              vel;
    logic              disc;
    logic              swap;
    logic              inv_s;
    logic              inv_c;
    logic              exceed;
    logic [ANG_W-1:0]  pos;
    logic [ACC_W-1:0]  step;
    logic [GAIN_W-1:0] gain_s;
    logic [GAIN_W-1:0] gain_c;
    logic [DLY_AW-1:0] dly_s;
    logic [DLY_AW-1:0] dly_c;
    logic [7:0]        spk_per;
  } rsv_cfg_t;

  function automatic rsv_cfg_t rsv_cfg_init();
    rsv_cfg_t c;
    c = '0;
    c.gain_s = GAIN_W'(1 << GAIN_SH);
    c.gain_c = GAIN_W'(1 << GAIN_SH);
    return c;
  endfunction

  // Excitation times trig value, rescaled so full scale lands at 2**(OUT_W-1).
  function automatic logic signed [PROD_W-1:0] rsv_mod(input logic signed [EXC_W-1:0] e,
                                                       input logic signed [TRIG_W-1:0] t);
    logic signed [47:0] ew, tw, p;
    ew = e;
    tw = t;
    p  = (ew * tw) >>> MOD_SH;
    return p[PROD_W-1:0];
  endfunction

  function automatic logic signed [WIDE_W-1:0] rsv_gain(input logic signed [PROD_W-1:0] v,
                                                        input logic [GAIN_W-1:0] g);
    logic signed [47:0] vw, gw, p;
    vw = v;
    gw = {32'd0, g};
    p  = (vw * gw) >>> GAIN_SH;
    return p[WIDE_W-1:0];
  endfunction

  function automatic logic signed [OUT_W-1:0] rsv_sat(input logic signed [47:0] v);
    logic signed [47:0] hi, lo;
    hi = (48'sd1 <<< (OUT_W - 1)) - 48'sd1;
    lo = -(48'sd1 <<< (OUT_W - 1));
    if (v > hi)      return hi[OUT_W-1:0];
    else if (v < lo) return lo[OUT_W-1:0];
    else             return v[OUT_W-1:0];
  endfunction

  // Output-side fault arithmetic: inversion, x4 overdrive, spike, clamp.
  function automatic logic signed [OUT_W-1:0] rsv_post(input logic signed [WIDE_W-1:0] v,
                                                       input logic inv, input logic ovd,
                                                       input logic spk,
                                                       input logic signed [WIDE_W-1:0] amp);
    logic signed [47:0] t, a;
    t = v;
    a = amp;
    if (inv) t = -t;
    if (ovd) t = t <<< 2;
    if (spk) t = t + a;
    return rsv_sat(t);
  endfunction

  function automatic logic signed [TRIG_W-1:0] rsv_trig_rnd(input logic signed [23:0] v);
    logic signed [23:0] r;
    r = (v + 24'sd8) >>> 4;
    return r[TRIG_W-1:0];
  endfunction

  // arctan(2**-i) in units of 2**-24 turn
  function automatic logic signed [23:0] rsv_atan(input int i);
    case (i)
      0:  return 24'sd2097152;
      1:  return 24'sd1238021;
      2:  return 24'sd654136;
      3:  return 24'sd332050;
      4:  return 24'sd166669;
      5:  return 24'sd83416;
      6:  return 24'sd41718;
      7:  return 24'sd20860;
      8:  return 24'sd10430;
      9:  return 24'sd5215;
      10: return 24'sd2608;
      11: return 24'sd1304;
      12: return 24'sd652;
      13: return 24'sd326;
      14: return 24'sd163;
      15: return 24'sd81;
      default: return 24'sd0;
    endcase
  endfunction
endpackage

// File: rtl/rsv_phase_acc.sv
`timescale 1ns/1ps
module rsv_phase_acc
  import rsv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             vel,
  input  logic [ANG_W-1:0] pos,
  input  logic [ACC_W-1:0] step,
  output logic [ANG_W-1:0] angle
);
  localparam int FRAC_W = ACC_W - ANG_W;

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (adv) acc <= vel ? acc + step : {pos, {FRAC_W{1'b0}}};
  end

  assign angle = vel ? acc[ACC_W-1 -: ANG_W] : pos;

  // R4: the accumulator only moves on a sample strobe
  p_acc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc));
endmodule

// File: rtl/rsv_cordic.sv
`timescale 1ns/1ps
module rsv_cordic
  import rsv_pkg::*;
#(
  parameter int ITERS = 16
)(
  input  logic [ANG_W-1:0]         angle,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  localparam int XY_W = 24;
  localparam int Z_W  = 24;
  localparam int PAD  = Z_W - ANG_W;
  localparam logic signed [XY_W-1:0] K_INIT = 24'sd636751;   // 0.60725 * 2**20

  logic signed [XY_W-1:0] xr, yr;

  always_comb begin
    logic signed [XY_W-1:0] x, y, xs, ys;
    logic signed [Z_W-1:0]  z;
    z = {angle, {PAD{1'b0}}};
    y = '0;
    if (angle[ANG_W-1] ^ angle[ANG_W-2]) begin
      x = -K_INIT;                    // fold second/third quadrant by half a turn
      z[Z_W-1] = ~z[Z_W-1];
    end else begin
      x = K_INIT;
    end
    for (int i = 0; i < ITERS; i++) begin
      xs = x >>> i;
      ys = y >>> i;
      if (!z[Z_W-1]) begin
        x = x - ys;
        y = y + xs;
        z = z - rsv_atan(i);
      end else begin
        x = x + ys;
        y = y - xs;
        z = z + rsv_atan(i);
      end
    end
    xr = x;
    yr = y;
  end

  assign cos_o = rsv_trig_rnd(xr);
  assign sin_o = rsv_trig_rnd(yr);
endmodule

// File: rtl/rsv_chan.sv
`timescale 1ns/1ps
module rsv_chan
  import rsv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic signed [PROD_W-1:0] din,
  input  logic [DLY_AW-1:0]        dly,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [WIDE_W-1:0] dout
);
  localparam int DEPTH = 1 << DLY_AW;

  logic signed [PROD_W-1:0] hist [DEPTH];
  logic [DLY_AW-1:0]        wptr, rptr;
  logic signed [PROD_W-1:0] tap;

  assign rptr = wptr - dly;
  assign tap  = (dly == '0) ? din : hist[rptr];
  assign dout = rsv_gain(tap, gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (adv) begin
      hist[wptr] <= din;
      wptr       <= wptr + 1'b1;
    end
  end

  // R10: history pointer advances only with samples
  p_ptr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(wptr));
endmodule

// File: rtl/rsv_synth.sv
`timescale 1ns/1ps
module rsv_synth
  import rsv_pkg::*;
#(
  parameter int SPIKE_AMP = 131072,
  parameter int ITERS     = 16
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [EXC_W-1:0] exc_in,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [15:0]             cfg_wdata,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out
);
  localparam logic signed [WIDE_W-1:0] SPK = WIDE_W'(SPIKE_AMP);

  rsv_cfg_t cfg_sh, cfg_act;
  logic     cfg_load;
  assign cfg_load = smp_vld;

  // shadow registers, written at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_sh <= rsv_cfg_init();
    else if (cfg_we) begin
      case (cfg_addr)
        3'd0: {cfg_sh.exceed, cfg_sh.inv_c, cfg_sh.inv_s,
               cfg_sh.swap, cfg_sh.disc, cfg_sh.vel} <= cfg_wdata[5:0];
        3'd1: cfg_sh.pos          <= cfg_wdata;
        3'd2: cfg_sh.step[31:16]  <= cfg_wdata;
        3'd3: cfg_sh.step[15:0]   <= cfg_wdata;
        3'd4: cfg_sh.gain_s       <= cfg_wdata;
        3'd5: cfg_sh.gain_c       <= cfg_wdata;
        3'd6: {cfg_sh.dly_c, cfg_sh.dly_s} <= cfg_wdata;
        default: cfg_sh.spk_per   <= cfg_wdata[7:0];
      endcase
    end
  end

  // active copy taken over only at a sample boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_act <= rsv_cfg_init();
    else if (cfg_load) cfg_act <= cfg_sh;
  end

  logic [ANG_W-1:0] angle;
  rsv_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .adv(smp_vld), .vel(cfg_act.vel),
    .pos(cfg_act.pos), .step(cfg_act.step), .angle(angle)
  );

  logic signed [TRIG_W-1:0] trig_s, trig_c;
  rsv_cordic #(.ITERS(ITERS)) u_cordic (.angle(angle), .sin_o(trig_s), .cos_o(trig_c));

  logic signed [PROD_W-1:0] ch_in   [2];
  logic [DLY_AW-1:0]        ch_dly  [2];
  logic [GAIN_W-1:0]        ch_gain [2];
  logic signed [WIDE_W-1:0] ch_out  [2];

  assign ch_in[0]   = rsv_mod(exc_in, trig_s);
  assign ch_in[1]   = rsv_mod(exc_in, trig_c);
  assign ch_dly[0]  = cfg_act.dly_s;
  assign ch_dly[1]  = cfg_act.dly_c;
  assign ch_gain[0] = cfg_act.gain_s;
  assign ch_gain[1] = cfg_act.gain_c;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    rsv_chan u_chan (
      .clk(clk), .rst_n(rst_n), .adv(smp_vld), .din(ch_in[g]),
      .dly(ch_dly[g]), .gain(ch_gain[g]), .dout(ch_out[g])
    );
  end

  // periodic spike
  logic [7:0] spk_cnt;
  logic       spike_now;
  assign spike_now = (cfg_act.spk_per != 8'd0) && (spk_cnt == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spk_cnt <= '0;
    else if (smp_vld) begin
      if (cfg_act.spk_per == 8'd0)                  spk_cnt <= '0;
      else if (spk_cnt >= cfg_act.spk_per - 8'd1)   spk_cnt <= '0;
      else                                          spk_cnt <= spk_cnt + 8'd1;
    end
  end

  // output fault muxing
  logic signed [WIDE_W-1:0] route_s, route_c;
  logic signed [OUT_W-1:0]  post_s, post_c, nxt_s, nxt_c;
  assign route_s = cfg_act.swap ? ch_out[1] : ch_out[0];
  assign route_c = cfg_act.swap ? ch_out[0] : ch_out[1];
  assign post_s  = rsv_post(route_s, cfg_act.inv_s, cfg_act.exceed, spike_now, SPK);
  assign post_c  = rsv_post(route_c, cfg_act.inv_c, cfg_act.exceed, spike_now, SPK);
  assign nxt_s   = cfg_act.disc ? '0 : post_s;
  assign nxt_c   = cfg_act.disc ? '0 : post_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      sin_out <= '0;
      cos_out <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        sin_out <= nxt_s;
        cos_out <= nxt_c;
      end
    end
  end

  // R1: one valid pulse per strobe, outputs hold between strobes
  p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!out_vld && $stable(sin_out) && $stable(cos_out)));
  // R11: active configuration changes only at a sample boundary
  p_cfg_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(cfg_act));
  // R6: disconnection yields zero on both lines
  p_disc_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_act.disc) |=> (sin_out == '0 && cos_out == '0));
  // R9: spike phase counter stays below the programmed period
  p_spike_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_act.spk_per != 8'd0) |=> (spk_cnt < $past(cfg_act.spk_per)));
endmodule

// File: tb/rsv_synth_bench.sv
`timescale 1ns/1ps
module rsv_synth_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_vld = 1'b0;
  logic signed [15:0] exc_in = '0;
  logic               cfg_we = 1'b0;
  logic [2:0]         cfg_addr = '0;
  logic [15:0]        cfg_wdata = '0;
  logic               out_vld;
  logic signed [19:0] sin_out, cos_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam int  TOL = 48;
  localparam real PI  = 3.14159265358979;

  always #2.5 clk = ~clk;

  rsv_synth u_rsv_synth (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .exc_in(exc_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_vld(out_vld), .sin_out(sin_out), .cos_out(cos_out)
  );

  function automatic real clip(input real v);
    if (v > 524287.0)  return 524287.0;
    if (v < -524288.0) return -524288.0;
    return v;
  endfunction

  function automatic real model(input int e, input int ang, input int g, input bit use_sin);
    real th, t;
    th = 2.0 * PI * real'(ang) / 65536.0;
    t  = use_sin ? $sin(th) : $cos(th);
    return clip(real'(e) * 16.0 * t * real'(g) / 32768.0);
  endfunction

  task automatic chk(input string req, input int act, input real exp, input int tol);
    real d;
    n_chk++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > real'(tol)) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0.1f", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input int e);
    smp_vld = 1'b1; exc_in = 16'(e);
    @(posedge clk); @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic settle();
    strobe(0);
    strobe(0);
  endtask

  task automatic t_reset();
    chk("R1 reset sin", sin_out, 0.0, 0);
    chk("R1 reset cos", cos_out, 0.0, 0);
    chk("R1 reset vld", out_vld, 0.0, 0);
  endtask

  task automatic t_position();
    int angs [6] = '{32'h0000, 32'h2000, 32'h6000, 32'hA000, 32'hE000, 32'h1555};
    int excs [2] = '{25000, -18000};
    int hold;
    foreach (angs[i]) begin
      wr(1, angs[i]);
      settle();
      foreach (excs[k]) begin
        strobe(excs[k]);
        chk("R1 vld after strobe", out_vld, 1.0, 0);
        chk("R2 sin", sin_out, model(excs[k], angs[i], 32768, 1'b1), TOL);
        chk("R2 cos", cos_out, model(excs[k], angs[i], 32768, 1'b0), TOL);
        hold = sin_out;
        @(negedge clk);
        chk("R1 vld drops", out_vld, 0.0, 0);
        chk("R1 hold", sin_out, real'(hold), 0);
      end
    end
    // R3 quadrant signs
    wr(1, 16'h6000); settle(); strobe(25000);
    chk("R3 q2 sin positive", (sin_out > 0), 1.0, 0);
    chk("R3 q2 cos antiphase", (cos_out < 0), 1.0, 0);
    wr(1, 16'hA000); settle(); strobe(25000);
    chk("R3 q3 sin antiphase", (sin_out < 0), 1.0, 0);
    chk("R3 q3 cos antiphase", (cos_out < 0), 1.0, 0);
    wr(1, 16'h2000); settle(); strobe(-18000);
    chk("R3 q1 negative exc sin", (sin_out < 0), 1.0, 0);
    chk("R3 q1 negative exc cos", (cos_out < 0), 1.0, 0);
  endtask

  task automatic t_velocity();
    longint step, acc;
    int ang;
    step = 64'h0000_0000_0100_8000;
    wr(0, 0); wr(1, 16'h3000); settle();
    wr(2, 16'h0100); wr(3, 16'h8000); wr(0, 1);
    strobe(0);                       // load strobe, still position mode
    for (int j = 0; j < 8; j++) begin
      acc = (64'h3000_0000 + longint'(j) * step) & 64'hFFFF_FFFF;
      ang = int'(acc >> 16);
      strobe(20000);
      chk("R4 velocity sin", sin_out, model(20000, ang, 32768, 1'b1), TOL);
      chk("R4 velocity cos", cos_out, model(20000, ang, 32768, 1'b0), TOL);
    end
    wr(0, 0); wr(1, 0); settle();
  endtask

  task automatic t_gain();
    wr(1, 16'h2000); wr(4, 16'h4000); wr(5, 16'hC000); settle();
    strobe(24000);
    chk("R5 sin gain 0.5", sin_out, model(24000, 16'h2000, 16'h4000, 1'b1), TOL);
    chk("R5 cos gain 1.5", cos_out, model(24000, 16'h2000, 16'hC000, 1'b0), TOL);
    wr(4, 16'h8000); wr(5, 16'h8000); settle();
  endtask

  task automatic t_saturate();
    wr(1, 16'h4000); wr(4, 16'hFFFF); settle();
    strobe(32767);
    chk("R8 positive clamp", sin_out, 524287.0, 0);
    chk("R8 cos near zero", cos_out, 0.0, TOL);
    strobe(-32768);
    chk("R8 negative clamp", sin_out, -524288.0, 0);
    wr(4, 16'h8000);
    wr(1, 16'h2000); wr(0, 16'h20); settle();
    strobe(2000);
    chk("R8 overdrive x4 sin", sin_out, 4.0 * model(2000, 16'h2000, 32768, 1'b1), 4 * TOL);
    chk("R8 overdrive x4 cos", cos_out, 4.0 * model(2000, 16'h2000, 32768, 1'b0), 4 * TOL);
    strobe(16384);
    chk("R8 overdrive clip high", sin_out, 524287.0, 0);
    strobe(-16384);
    chk("R8 overdrive clip low", cos_out, -524288.0, 0);
    wr(0, 0); settle();
  endtask

  task automatic t_disconnect();
    wr(1, 16'h2000); wr(0, 16'h02); settle();
    strobe(30000);
    chk("R6 disc sin zero", sin_out, 0.0, 0);
    chk("R6 disc cos zero", cos_out, 0.0, 0);
    wr(0, 0); settle();
  endtask

  task automatic t_swap();
    wr(1, 16'h1000); wr(0, 16'h04); settle();
    strobe(20000);
    chk("R7 swap sin pin", sin_out, model(20000, 16'h1000, 32768, 1'b0), TOL);
    chk("R7 swap cos pin", cos_out, model(20000, 16'h1000, 32768, 1'b1), TOL);
    wr(0, 16'h0C); settle();
    strobe(20000);
    chk("R7 swap+inv sin pin", sin_out, -model(20000, 16'h1000, 32768, 1'b0), TOL);
    chk("R7 cos untouched", cos_out, model(20000, 16'h1000, 32768, 1'b1), TOL);
    wr(0, 16'h10); settle();
    strobe(20000);
    chk("R7 inv cos", cos_out, -model(20000, 16'h1000, 32768, 1'b0), TOL);
    wr(0, 0); settle();
  endtask

  task automatic t_delay();
    int e [8];
    wr(1, 16'h2000); settle();
    wr(6, 16'h0103);                 // cos delay 1, sin delay 3
    strobe(0);
    for (int k = 0; k < 8; k++) begin
      e[k] = 1000 * (k + 1);
      strobe(e[k]);
      if (k >= 3) chk("R10 sin delayed 3", sin_out, model(e[k-3], 16'h2000, 32768, 1'b1), TOL);
      if (k >= 1) chk("R10 cos delayed 1", cos_out, model(e[k-1], 16'h2000, 32768, 1'b0), TOL);
    end
    wr(6, 0); settle();
  endtask

  task automatic t_spike();
    real exp;
    wr(1, 0); settle();
    wr(7, 4);
    strobe(0);
    chk("R9 no spike before load", sin_out, 0.0, 0);
    for (int j = 0; j < 9; j++) begin
      strobe(0);
      exp = (j % 4 == 0) ? 131072.0 : 0.0;
      chk("R9 spike sin", sin_out, exp, 0);
      chk("R9 spike cos", cos_out, exp, 0);
    end
    wr(7, 0); settle();
  endtask

  task automatic t_boundary();
    wr(1, 16'h2000); settle();
    wr(0, 16'h02);
    strobe(20000);
    chk("R11 old config on next strobe", sin_out, model(20000, 16'h2000, 32768, 1'b1), TOL);
    strobe(20000);
    chk("R11 new config after", sin_out, 0.0, 0);
    wr(0, 0); wr(0, 16'h02); wr(0, 0);
    strobe(20000);
    chk("R11 still old (disc)", cos_out, 0.0, 0);
    strobe(20000);
    chk("R11 last write wins", cos_out, model(20000, 16'h2000, 32768, 1'b0), TOL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_position();
    t_velocity();
    t_gain();
    t_saturate();
    t_disconnect();
    t_swap();
    t_delay();
    t_spike();
    t_boundary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule